// File: doc/BRIEF.md
# Asynchronous Byte-Write Port with Short-Packet Commit

This block is the device side of an asynchronous byte-write port that feeds four independent FIFOs. An external agent drives a byte, a 2-bit FIFO address and three active-low strobes: write, chip select and packet end. The block brings the strobes into its own clock domain through two-flop synchronizers. It acts on the release, or rising, edge of each strobe. A write release stores the byte in the addressed FIFO at the current write pointer and then advances that pointer.

A packet-end release turns the bytes gathered since the last commit into a packet, which may be short or even empty. The packet is offered downstream as a valid/ready record. The record gives the FIFO index, the byte count, the packet's starting pointer and an XOR check byte of its contents, so the stored data can be seen at the boundary. Each FIFO holds at most one packet waiting for handoff, and a packet's bytes count against the FIFO's capacity until it is handed off.

Each FIFO has a full flag. The flag reaches the outputs through a fixed pipeline, so it changes a set number of cycles after the strobe release that caused the change. Each FIFO also has a sticky overflow bit.

Top module: `slave_fifo_commit`

## Requirements
- R1: A byte is stored only when the write strobe returns high. Holding the strobe low for any number of cycles stores nothing.
- R2: Each FIFO's write pointer is post-incremented. A byte goes to the current location and the pointer then advances by one, wrapping to 0 after DEPTH-1. A packet's `pkt_base` is the pointer value of its first byte (or, for an empty packet, of the next free location), and it starts at 0 after reset.
- R3: `full[i]` is 1 when FIFO i holds DEPTH bytes (open bytes plus a packet waiting for handoff). A change caused by a strobe release appears at edge k+2+FLAG_DLY, where k is the first clock edge that sees the released strobe.
- R4: A packet-end release commits all open bytes of the addressed FIFO as one packet. Its `pkt_len` is the byte count and its `pkt_sum` is the XOR of its bytes. For example, four writes followed by a packet end give one packet with length 4.
- R5: A packet end with no open bytes commits a packet with length 0 and check byte 0.
- R6: `fifo_sel` (FIFO 0 to 3) picks the FIFO that a write or packet end acts on. `pkt_fifo` reports that index, and the FIFOs' contents are independent of each other.
- R7: While the synchronized chip select is high, write and packet-end releases have no effect.
- R8: A write to a full FIFO is dropped, and a packet end to a FIFO whose previous packet still waits for handoff is dropped. Either event sets that FIFO's `overflow` bit, which stays set until reset.
- R9: While `pkt_valid` is 1 and `pkt_ready` is 0, the offered record holds steady. When no record is held, the lowest-numbered waiting FIFO is offered. A handoff (`pkt_valid` and `pkt_ready` both 1 at an edge) frees that packet's bytes.
- R10: After reset, `full`, `overflow` and `pkt_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_strobe_n | input | 1 | Asynchronous write strobe, active low |
| chip_sel_n | input | 1 | Asynchronous chip select, active low |
| pkt_end_n | input | 1 | Asynchronous packet-end strobe, active low |
| fifo_sel | input | 2 | Target FIFO index |
| wr_data | input | 8 | Byte to be written |
| full | output | 4 | Delayed full flag per FIFO |
| overflow | output | 4 | Sticky overflow bit per FIFO |
| pkt_valid | output | 1 | Committed packet offered |
| pkt_ready | input | 1 | Downstream accepts the offered packet |
| pkt_fifo | output | 2 | FIFO index of the offered packet |
| pkt_len | output | LEN_W | Byte count of the offered packet |
| pkt_base | output | PTR_W | Pointer of the packet's first byte |
| pkt_sum | output | 8 | XOR of the packet's bytes |

## Verification
Counting k as the first edge that sees a released strobe, the FIFO state changes at edge k+2. A committed record shows on `pkt_valid` in the cycle after that edge. `full` follows at edge k+2+FLAG_DLY. The bench drives strobes on falling edges and waits several cycles after each release, so every record and flag it then samples has settled. The flag-latency check counts edges exactly: it samples once just before edge k+2+FLAG_DLY and once just after it. Records are checked as they are handed off, against a queue that bench functions fill from the requirements.

// File: rtl/slave_fifo_pkg.sv
package slave_fifo_pkg;
  localparam int SEL_W    = 2;
  localparam int NUM_FIFO = 1 << SEL_W;
  localparam int BYTE_W   = 8;

  // running check byte of a packet
  function automatic logic [BYTE_W-1:0] sum_fold(input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    return acc ^ b;
  endfunction
endpackage

// File: rtl/slave_fifo_sync.sv
module slave_fifo_sync #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic released
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= IDLE;
      s2   <= IDLE;
      prev <= IDLE;
    end else begin
      s1   <= async_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign level    = s2;
  assign released = s2 & ~prev;
endmodule

// File: rtl/slave_fifo_delay.sv
module slave_fifo_delay #(
  parameter int W      = 4,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/slave_fifo_lane.sv
module slave_fifo_lane
  import slave_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int LEN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              end_ev,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic              full,
  output logic              ovf,
  output logic              pend,
  output logic [LEN_W-1:0]  pend_len,
  output logic [PTR_W-1:0]  pend_base,
  output logic [BYTE_W-1:0] pend_sum
);
  localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DEPTH - 1);
  localparam logic [LEN_W:0]   DEPTH_OCC = (LEN_W+1)'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_adv(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [LEN_W:0] occ_of(input logic [LEN_W-1:0] open_n,
                                            input logic held,
                                            input logic [LEN_W-1:0] held_n);
    return {1'b0, open_n} + (held ? {1'b0, held_n} : '0);
  endfunction

  logic [PTR_W-1:0]  ptr, open_base;
  logic [LEN_W-1:0]  open_len;
  logic [BYTE_W-1:0] open_sum;
  logic [LEN_W:0]    occ;
  logic              accept, drop_wr, commit, drop_end;

  assign occ      = occ_of(open_len, pend, pend_len);
  assign full     = (occ >= DEPTH_OCC);
  assign accept   = wr_ev & ~full;
  assign drop_wr  = wr_ev & full;
  assign commit   = end_ev & (~pend | take);
  assign drop_end = end_ev & pend & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      open_base <= '0;
      open_len  <= '0;
      open_sum  <= '0;
      pend      <= 1'b0;
      pend_len  <= '0;
      pend_base <= '0;
      pend_sum  <= '0;
      ovf       <= 1'b0;
    end else begin
      if (accept) ptr <= ptr_adv(ptr);
      if (commit) begin
        pend      <= 1'b1;
        pend_len  <= open_len;
        pend_base <= open_base;
        pend_sum  <= open_sum;
        open_len  <= accept ? LEN_W'(1) : '0;
        open_sum  <= accept ? din : '0;
        open_base <= ptr;
      end else begin
        if (take) pend <= 1'b0;
        if (accept) begin
          open_len <= open_len + 1'b1;
          open_sum <= sum_fold(open_sum, din);
        end
      end
      if (drop_wr | drop_end) ovf <= 1'b1;
    end
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_OCC);
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> (pend && $stable(pend_len) && $stable(pend_sum) && $stable(pend_base)));
endmodule

// File: rtl/slave_fifo_commit.sv
module slave_fifo_commit
  import slave_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int FLAG_DLY = 3,
  parameter int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int LEN_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe_n,
  input  logic              chip_sel_n,
  input  logic              pkt_end_n,
  input  logic [SEL_W-1:0]  fifo_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NUM_FIFO-1:0] full,
  output logic [NUM_FIFO-1:0] overflow,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [SEL_W-1:0]  pkt_fifo,
  output logic [LEN_W-1:0]  pkt_len,
  output logic [PTR_W-1:0]  pkt_base,
  output logic [BYTE_W-1:0] pkt_sum
);
  // strobe order: 0 write, 1 chip select, 2 packet end
  logic [2:0] raw_n, lvl, rel;
  assign raw_n = {pkt_end_n, chip_sel_n, wr_strobe_n};

  for (genvar s = 0; s < 3; s++) begin : g_sync
    slave_fifo_sync #(.IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw_n[s]),
      .level(lvl[s]), .released(rel[s]));
  end

  logic cs_act, wr_release, end_release;
  assign cs_act      = ~lvl[1];
  assign wr_release  = rel[0] & cs_act;
  assign end_release = rel[2] & cs_act;

  logic [NUM_FIFO-1:0] lane_wr, lane_end, lane_take, lane_full, lane_pend;
  logic [LEN_W-1:0]    lane_len  [NUM_FIFO];
  logic [PTR_W-1:0]    lane_base [NUM_FIFO];
  logic [BYTE_W-1:0]   lane_sum  [NUM_FIFO];
  logic [SEL_W-1:0]    pick, cur, sel_q;
  logic                lock_q;

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_lane
    assign lane_wr[i]   = wr_release  & (fifo_sel == SEL_W'(i));
    assign lane_end[i]  = end_release & (fifo_sel == SEL_W'(i));
    assign lane_take[i] = pkt_valid & pkt_ready & (cur == SEL_W'(i));

    slave_fifo_lane #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .wr_ev(lane_wr[i]), .end_ev(lane_end[i]), .take(lane_take[i]),
      .din(wr_data),
      .full(lane_full[i]), .ovf(overflow[i]), .pend(lane_pend[i]),
      .pend_len(lane_len[i]), .pend_base(lane_base[i]), .pend_sum(lane_sum[i]));
  end

  always_comb begin
    pick = '0;
    for (int i = NUM_FIFO - 1; i >= 0; i--)
      if (lane_pend[i]) pick = SEL_W'(i);
  end

  assign cur       = lock_q ? sel_q : pick;
  assign pkt_valid = |lane_pend;
  assign pkt_fifo  = cur;
  assign pkt_len   = lane_len[cur];
  assign pkt_base  = lane_base[cur];
  assign pkt_sum   = lane_sum[cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      lock_q <= pkt_valid & ~pkt_ready;
      sel_q  <= cur;
    end
  end

  slave_fifo_delay #(.W(NUM_FIFO), .STAGES(FLAG_DLY)) u_flag_dly (
    .clk(clk), .rst_n(rst_n), .d(lane_full), .q(full));

  // R9
  stream_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_fifo) && $stable(pkt_len)
                                   && $stable(pkt_base) && $stable(pkt_sum)));
  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_wr) && $onehot0(lane_end));
endmodule

// File: tb/slave_fifo_commit_bench.sv
module slave_fifo_commit_bench;
  localparam int DEPTH = 16;
  localparam int DLY   = 3;
  localparam int PTR_W = 4;
  localparam int LEN_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, cs_n = 1'b1, pe_n = 1'b1;
  logic [1:0] sel = '0;
  logic [7:0] dat = '0;
  logic [3:0] full, ovf;
  logic pkt_valid, pkt_ready = 1'b1;
  logic [1:0] pkt_fifo;
  logic [LEN_W-1:0] pkt_len;
  logic [PTR_W-1:0] pkt_base;
  logic [7:0] pkt_sum;

  always #2.5 clk = ~clk;

  slave_fifo_commit #(.DEPTH(DEPTH), .FLAG_DLY(DLY)) u_slave_fifo_commit (
    .clk(clk), .rst_n(rst_n), .wr_strobe_n(wr_n), .chip_sel_n(cs_n),
    .pkt_end_n(pe_n), .fifo_sel(sel), .wr_data(dat), .full(full),
    .overflow(ovf), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_fifo(pkt_fifo), .pkt_len(pkt_len), .pkt_base(pkt_base), .pkt_sum(pkt_sum));

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { int f; int len; int base; int sum; } pkt_t;
  pkt_t expq[$];

  int m_ptr[4], m_len[4], m_sum[4], m_base[4], m_out_len[4];
  bit m_busy[4], m_ovf[4];

  function automatic int nxt(int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // handoff monitor: R4 R2 R6 R9
  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R4 unexpected packet", int'(pkt_fifo), -1);
      end else begin
        pkt_t p;
        p = expq.pop_front();
        checks++;
        if (int'(pkt_fifo) != p.f || int'(pkt_len) != p.len ||
            int'(pkt_base) != p.base || int'(pkt_sum) != p.sum) begin
          fails++;
          $display("FAIL R4 R2 R6 packet actual f=%0d len=%0d base=%0d sum=%0d expected f=%0d len=%0d base=%0d sum=%0d",
                   pkt_fifo, pkt_len, pkt_base, pkt_sum, p.f, p.len, p.base, p.sum);
        end
        m_busy[p.f] = 0;
        m_out_len[p.f] = 0;
      end
    end
  end

  task automatic set_ready(bit r);
    @(posedge clk); #1 pkt_ready = r;
  endtask

  task automatic model_wr(int f, int d);
    if (m_len[f] + m_out_len[f] >= DEPTH) m_ovf[f] = 1;
    else begin
      m_len[f]++;
      m_sum[f] ^= d;
      m_ptr[f] = nxt(m_ptr[f]);
    end
  endtask

  task automatic model_end(int f);
    pkt_t p;
    if (m_busy[f]) m_ovf[f] = 1;
    else begin
      p.f = f; p.len = m_len[f]; p.base = m_base[f]; p.sum = m_sum[f];
      expq.push_back(p);
      m_busy[f] = 1;
      m_out_len[f] = m_len[f];
      m_len[f] = 0; m_sum[f] = 0; m_base[f] = m_ptr[f];
    end
  endtask

  task automatic strobe_lo(int f, int d, bit cs);
    @(negedge clk);
    sel = 2'(f); dat = 8'(d); cs_n = ~cs;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(int f, int d, bit cs);
    strobe_lo(f, d, cs);
    wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1;
    if (cs) model_wr(f, d);
    repeat (3) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_end(int f, bit cs);
    strobe_lo(f, 0, cs);
    pe_n = 0;
    repeat (3) @(negedge clk);
    pe_n = 1;
    if (cs) model_end(f);
    repeat (3) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin
      m_ptr[i] = 0; m_len[i] = 0; m_sum[i] = 0; m_base[i] = 0;
      m_out_len[i] = 0; m_busy[i] = 0; m_ovf[i] = 0;
    end
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(full == 4'h0, "R10 full", int'(full), 0);
    chk(ovf == 4'h0, "R10 overflow", int'(ovf), 0);
    chk(pkt_valid == 1'b0, "R10 pkt_valid", int'(pkt_valid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R5 empty packet on FIFO 2
    do_end(2, 1);
    chk(expq.size() == 0, "R5 empty packet delivered", expq.size(), 0);

    // R7 chip select inactive: write and packet end ignored on FIFO 3
    do_write(3, 8'h5a, 0);
    do_end(3, 0);
    chk(pkt_valid == 0 && expq.size() == 0, "R7 ignored strobes", int'(pkt_valid), 0);
    do_end(3, 1); // must be a zero-length packet at base 0
    chk(expq.size() == 0, "R7 follow-up packet", expq.size(), 0);

    // R1 R3 fill FIFO 1 to DEPTH-1, then time the last write
    for (int i = 0; i < DEPTH - 1; i++) do_write(1, i * 7 + 3, 1);
    strobe_lo(1, 8'hc3, 1);
    wr_n = 0;
    repeat (10) @(negedge clk);
    chk(full[1] == 0, "R1 held-low strobe stored nothing", int'(full[1]), 0);
    wr_n = 1;
    model_wr(1, 8'hc3);
    repeat (2 + DLY) @(posedge clk);
    @(negedge clk);
    chk(full[1] == 0, "R3 flag before delay", int'(full[1]), 0);
    @(posedge clk);
    @(negedge clk);
    chk(full[1] == 1, "R3 flag after delay", int'(full[1]), 1);
    cs_n = 1;
    repeat (3) @(negedge clk);
    // R8 write while full is dropped
    do_write(1, 8'hff, 1);
    repeat (DLY + 2) @(negedge clk);
    chk(ovf[1] == 1, "R8 overflow on full write", int'(ovf[1]), 1);
    chk(ovf[0] == 0, "R6 other FIFO overflow untouched", int'(ovf[0]), 0);
    do_end(1, 1);
    repeat (DLY + 4) @(negedge clk);
    chk(full[1] == 0, "R9 handoff frees space", int'(full[1]), 0);
    // R2 pointer wrapped: next packet starts at 0
    do_write(1, 8'h11, 1);
    do_end(1, 1);

    // R9 hold with ready low
    set_ready(0);
    do_write(3, 8'h21, 1);
    do_write(3, 8'h42, 1);
    do_end(3, 1);
    chk(pkt_valid == 1 && pkt_fifo == 2'd3, "R9 offered FIFO 3", int'(pkt_fifo), 3);
    do_write(1, 8'h99, 1);
    do_end(1, 1);
    chk(pkt_fifo == 2'd3 && pkt_len == LEN_W'(2), "R9 held record stable", int'(pkt_len), 2);
    do_end(3, 1);
    repeat (2) @(negedge clk);
    chk(ovf[3] == 1, "R8 packet end while waiting", int'(ovf[3]), 1);
    set_ready(1);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R9 both delivered in order", expq.size(), 0);

    // random phase: R4 R2 R6 R7
    for (int n = 0; n < 300; n++) begin
      int f, op;
      bit cs;
      f  = int'($urandom_range(0, 3));
      op = int'($urandom_range(0, 5));
      cs = ($urandom_range(0, 7) != 0);
      if (op == 0) do_end(f, cs);
      else do_write(f, int'($urandom_range(0, 255)), cs);
    end
    for (int f = 0; f < 4; f++) do_end(f, 1);
    repeat (DLY + 4) @(negedge clk);
    chk(expq.size() == 0, "R4 all packets delivered", expq.size(), 0);
    for (int f = 0; f < 4; f++)
      chk(ovf[f] == m_ovf[f], "R8 sticky overflow", int'(ovf[f]), int'(m_ovf[f]));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule